// File: doc/BRIEF.md
# Per-Profile PI Amplitude Servo

This block closes an amplitude loop for one synthesizer channel. Each ADC sample that arrives with its valid strobe is compared against a setpoint. A proportional-integral law turns the difference into an unsigned 14-bit amplitude-scale word. The word is purely the PI response to the error: no offset is multiplied in or added.

The integrator state is kept once for every profile. When a channel hops between profiles, for example between tones, each profile resumes from its own accumulated value. A hold input freezes integration while the proportional path keeps working. A sticky railed flag records that the output hit either end of its range, so that software can read it out later.

The block accepts one sample per clock cycle, which leaves ample margin for a one-megasample-per-second loop. Each result appears a fixed two cycles after its sample.

Top module: `pi_amp_servo`

## Requirements
- R1: With err = adcSample - setpoint, where the sample and setpoint are 16-bit signed, the profile integrator candidate is I' = I + ki*err. The pre-shift sum is kp*err + I', and the output is that sum arithmetically shifted right by 8 bits (floor), then clamped as in R3. kp and ki are 16-bit signed gains.
- R2: ampValid is high exactly two rising edges after each cycle with adcValid high, and is low otherwise. Samples may arrive on consecutive cycles. ampWord changes only on cycles where ampValid is high.
- R3: A shifted sum below 0 gives ampWord 0, and a shifted sum above 16383 gives ampWord 16383. Both are saturated results.
- R4: When holdIn is high with a valid sample, the selected profile's integrator keeps its value. The output then uses kp*err + I, with the stored I.
- R5: profSel, which is 2 bits, is sampled with adcValid. It selects which of 4 independent integrators is read and updated. The other integrators are untouched.
- R6: On a saturated-high result the integrator is not updated if ki*err > 0. On a saturated-low result it is not updated if ki*err < 0. Otherwise I' is stored.
- R7: railed goes high on the edge that produces a saturated result, and stays high until railClr is high at a clock edge.
- R8: When railClr is high at the same edge that produces a saturated result, railed is high after that edge.
- R9: After reset, ampValid = 0, ampWord = 0, railed = 0, and all integrators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcValid | input | 1 | Sample strobe |
| adcSample | input | 16 | Signed ADC sample |
| setpoint | input | 16 | Signed target level |
| kp | input | 16 | Signed proportional gain, 8 fractional bits |
| ki | input | 16 | Signed integral gain, 8 fractional bits |
| profSel | input | 2 | Profile selecting the integrator |
| holdIn | input | 1 | Freeze integration for this sample |
| railClr | input | 1 | Clear the railed flag |
| ampValid | output | 1 | Result strobe |
| ampWord | output | 14 | Unsigned amplitude-scale word |
| railed | output | 1 | Sticky saturation flag |

## Verification
Directed patterns come first.
- A pure proportional case with unity gain and no integral gain isolates the shift and clamp from the accumulator.
- A run with integral gain at one fixed profile shows accumulation.
- Interleaving profiles tells per-profile state apart from a shared integrator.
- Holding samples separate a frozen integrator from one that keeps running.

Long drives into the upper rail followed by a reversed error distinguish anti-windup from plain accumulation. Timing a clear against a saturating result checks that a new saturation wins over the clear.

Back-to-back random samples with random gains, profiles and hold then exercise both rails and the pipeline at full rate.

// File: rtl/pi_servo_pkg.sv
package pi_servo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load stage-1 operands
    logic compute;   // stage-2 result is live this cycle
    logic freeze;    // integrator must keep its value
  } servo_strobe_t;
endpackage

// File: rtl/pi_servo_ctrl.sv
module pi_servo_ctrl
  import pi_servo_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          adcValid,
  input  logic          holdIn,
  input  logic          railClr,
  input  logic          satNow,
  output servo_strobe_t strobe,
  output logic          ampValid,
  output logic          railed
);
  logic validQ;
  logic holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      holdQ    <= 1'b0;
      ampValid <= 1'b0;
      railed   <= 1'b0;
    end else begin
      validQ   <= adcValid;
      holdQ    <= adcValid & holdIn;
      ampValid <= validQ;
      // a fresh saturation wins over a clear on the same edge
      railed   <= (validQ & satNow) | (railed & ~railClr);
    end
  end

  always_comb begin
    strobe.capture = adcValid;
    strobe.compute = validQ;
    strobe.freeze  = holdQ;
  end
endmodule

// File: rtl/pi_servo_datapath.sv
module pi_servo_datapath
  import pi_servo_pkg::*;
#(
  parameter int ADC_W  = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 8,
  parameter int ACC_W  = 40,
  parameter int OUT_W  = 14,
  parameter int NPROF  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  servo_strobe_t            strobe,
  input  logic signed [ADC_W-1:0]  adcSample,
  input  logic signed [ADC_W-1:0]  setpoint,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic [$clog2(NPROF)-1:0] profSel,
  output logic [OUT_W-1:0]         ampWord,
  output logic                     satNow
);
  localparam int PROF_W = $clog2(NPROF);
  localparam int ERR_W  = ADC_W + 1;
  localparam int PROD_W = ERR_W + GAIN_W;
  localparam int SUM_W  = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((1 << OUT_W) - 1);

  logic signed [ERR_W-1:0]  errQ;
  logic signed [GAIN_W-1:0] kpQ, kiQ;
  logic [PROF_W-1:0]        profQ;

  logic signed [ACC_W-1:0]  accMem [NPROF];
  logic signed [PROD_W-1:0] pTerm, iInc;
  logic signed [ACC_W-1:0]  accSel, accCand;
  logic signed [SUM_W-1:0]  sumW, rawW;
  logic satHi, satLo, incPos, incNeg, allowCommit;

  // stage 1: error and operand capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ  <= '0;
      kpQ   <= '0;
      kiQ   <= '0;
      profQ <= '0;
    end else if (strobe.capture) begin
      errQ  <= ERR_W'(adcSample) - ERR_W'(setpoint);
      kpQ   <= kp;
      kiQ   <= ki;
      profQ <= profSel;
    end
  end

  // stage 2: products, accumulate, shift, clamp
  always_comb begin
    pTerm   = PROD_W'(errQ) * PROD_W'(kpQ);
    iInc    = PROD_W'(errQ) * PROD_W'(kiQ);
    accSel  = accMem[profQ];
    accCand = accSel + ACC_W'(iInc);
    sumW    = SUM_W'(pTerm) + (strobe.freeze ? SUM_W'(accSel) : SUM_W'(accCand));
    rawW    = sumW >>> FRAC;
    satLo   = rawW[SUM_W-1];
    satHi   = !satLo && (rawW > OUT_MAX);
    satNow  = satHi | satLo;
    incNeg  = iInc[PROD_W-1];
    incPos  = !incNeg && (|iInc);
    allowCommit = strobe.compute && !strobe.freeze &&
                  !(satHi && incPos) && !(satLo && incNeg);
  end

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        accMem[g] <= '0;
      else if (allowCommit && (profQ == PROF_W'(g)))
        accMem[g] <= accCand;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ampWord <= '0;
    else if (strobe.compute)
      ampWord <= satHi ? '1 : (satLo ? '0 : rawW[OUT_W-1:0]);
  end
endmodule

// File: rtl/pi_amp_servo.sv
module pi_amp_servo
  import pi_servo_pkg::*;
#(
  parameter int ADC_W  = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 8,
  parameter int ACC_W  = 40,
  parameter int OUT_W  = 14,
  parameter int NPROF  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     adcValid,
  input  logic signed [ADC_W-1:0]  adcSample,
  input  logic signed [ADC_W-1:0]  setpoint,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic [$clog2(NPROF)-1:0] profSel,
  input  logic                     holdIn,
  input  logic                     railClr,
  output logic                     ampValid,
  output logic [OUT_W-1:0]         ampWord,
  output logic                     railed
);
  servo_strobe_t strobe;
  logic          satNow;

  pi_servo_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .holdIn(holdIn),
    .railClr(railClr), .satNow(satNow), .strobe(strobe),
    .ampValid(ampValid), .railed(railed)
  );

  pi_servo_datapath #(
    .ADC_W(ADC_W), .GAIN_W(GAIN_W), .FRAC(FRAC),
    .ACC_W(ACC_W), .OUT_W(OUT_W), .NPROF(NPROF)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcSample(adcSample),
    .setpoint(setpoint), .kp(kp), .ki(ki), .profSel(profSel),
    .ampWord(ampWord), .satNow(satNow)
  );
endmodule

// File: rtl/pi_servo_checker.sv
module pi_servo_checker #(
  parameter int OUT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             adcValid,
  input logic             railClr,
  input logic             ampValid,
  input logic [OUT_W-1:0] ampWord,
  input logic             railed
);
  logic v1, v2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= adcValid;
      v2 <= v1;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    ampValid == v2);

  assert_word_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ampValid |-> $stable(ampWord));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    railed && !railClr |=> railed);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    railClr |=> (!railed || ampValid));

  // R3 / R8: the flag only rises with a result pinned at a rail
  assert_rise_on_rail_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railed) |-> ampValid && (ampWord == '0 || ampWord == '1));
endmodule

bind pi_amp_servo pi_servo_checker #(.OUT_W(OUT_W)) i_chk (
  .clk(clk), .rstN(rstN), .adcValid(adcValid), .railClr(railClr),
  .ampValid(ampValid), .ampWord(ampWord), .railed(railed)
);

// File: tb/test_pi_amp_servo.sv
module test_pi_amp_servo;
  localparam int CLK_PERIOD = 10;
  localparam longint OUT_MAX = 16383;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adcValid = 1'b0;
  logic signed [15:0] adcSample = '0, setpoint = '0, kp = '0, ki = '0;
  logic [1:0] profSel = '0;
  logic holdIn = 1'b0, railClr = 1'b0;
  logic ampValid;
  logic [13:0] ampWord;
  logic railed;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  longint accModel [4];
  bit pv1 = 0, pv2 = 0, ps1 = 0;
  longint pw1 = 0, pw2 = 0;
  bit rExp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pi_amp_servo i_pi_amp_servo (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .adcSample(adcSample),
    .setpoint(setpoint), .kp(kp), .ki(ki), .profSel(profSel),
    .holdIn(holdIn), .railClr(railClr), .ampValid(ampValid),
    .ampWord(ampWord), .railed(railed)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model of one sample (R1, R3, R4, R5, R6)
  task automatic model(input int smp, input int sp, input int pr, input bit hd,
                       output longint word, output bit sat);
    longint err, inc, cand, sum, raw;
    bit hi, lo;
    err  = longint'(smp) - longint'(sp);
    inc  = err * longint'(ki);
    cand = accModel[pr] + inc;
    sum  = err * longint'(kp) + (hd ? accModel[pr] : cand);
    raw  = sum >>> 8;
    lo   = raw < 0;
    hi   = raw > OUT_MAX;
    sat  = hi | lo;
    word = hi ? OUT_MAX : (lo ? 0 : raw);
    if (!hd && !(hi && inc > 0) && !(lo && inc < 0))
      accModel[pr] = cand;
  endtask

  // called at a falling edge: check outputs, drive next inputs, advance model
  task automatic step(input bit v, input int smp, input int sp, input int pr,
                      input bit hd, input bit clr, input string tag);
    longint w;
    bit s;
    check({tag, " R2 ampValid"}, longint'(ampValid), longint'(pv2));
    if (pv2) check({tag, " R1 ampWord"}, longint'(ampWord), pw2);
    check({tag, " R7 railed"}, longint'(railed), longint'(rExp));
    adcValid  = v;
    adcSample = 16'(smp);
    setpoint  = 16'(sp);
    profSel   = 2'(pr);
    holdIn    = hd;
    railClr   = clr;
    w = 0;
    s = 0;
    if (v) model(int'(16'sh0 + $signed(16'(smp))), int'($signed(16'(sp))), pr, hd, w, s);
    rExp = (pv1 && ps1) ? 1'b1 : (clr ? 1'b0 : rExp);
    pv2 = pv1; pw2 = pw1;
    pv1 = v; pw1 = w; ps1 = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) accModel[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 ampValid", longint'(ampValid), 0);
    check("R9 ampWord", longint'(ampWord), 0);
    check("R9 railed", longint'(railed), 0);

    // R1: unity proportional, no integral
    kp = 16'sd256; ki = 16'sd0;
    step(1, 1000, 0, 0, 0, 0, "R1 prop");
    step(1, 3000, 500, 0, 0, 0, "R1 prop offset");
    idle(2, "R1 drain");
    // R3: saturate low, then high
    step(1, -5, 0, 0, 0, 0, "R3 low rail");
    idle(2, "R3 drain");
    step(1, 0, 0, 0, 0, 1, "R7 clear");
    step(1, 30000, -30000, 0, 0, 0, "R3 high rail");
    idle(3, "R7 sticky");
    step(0, 0, 0, 0, 0, 1, "R7 clear");
    idle(2, "R7 cleared");

    // R8: clear on the same edge as a saturating result
    step(1, 32000, 0, 1, 0, 0, "R8 sat");
    step(0, 0, 0, 0, 0, 1, "R8 clr coincident");
    idle(3, "R8 after");
    step(0, 0, 0, 0, 0, 1, "R7 clear");

    // R1/R5: integral per profile
    kp = 16'sd64; ki = 16'sd32;
    for (int i = 0; i < 6; i++) step(1, 200 + 50*i, 100, i % 2, 0, 0, "R5 interleave");
    idle(2, "R5 drain");
    step(1, 100, 100, 0, 0, 0, "R5 read p0");
    step(1, 100, 100, 1, 0, 0, "R5 read p1");
    step(1, 100, 100, 2, 0, 0, "R5 read p2 untouched");
    idle(2, "R5 drain");

    // R4: hold freezes the integrator
    for (int i = 0; i < 3; i++) step(1, 900, 100, 0, 1, 0, "R4 hold");
    step(1, 100, 100, 0, 0, 0, "R4 after hold");
    idle(2, "R4 drain");

    // R6: drive deep into the upper rail, then reverse
    kp = 16'sd16; ki = 16'sd200;
    for (int i = 0; i < 20; i++) step(1, 20000, 0, 3, 0, 0, "R6 windup");
    for (int i = 0; i < 6; i++) step(1, -2000, 0, 3, 0, 0, "R6 recover");
    idle(2, "R6 drain");
    step(0, 0, 0, 0, 0, 1, "R7 clear");

    // random, back-to-back (R2) with mixed gains and profiles
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        kp = 16'($signed(($urandom % 1201)) - 600);
        ki = 16'($signed(($urandom % 129)) - 64);
      end
      step(($urandom % 4) != 0, int'($urandom % 65536) - 32768,
           int'($urandom % 4001) - 2000, int'($urandom % 4),
           ($urandom % 8) == 0, ($urandom % 16) == 0, "R2 random");
    end
    idle(3, "R2 final drain");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule